// File: doc/BRIEF.md
# Card Function Status Register Block

This block gives a card function four 16-bit status registers behind a simple word-addressed write port with a combinational read port. Six card status lines feed a present-state view: write protect, ready, two battery-voltage-detect lines, general wake and interrupt request. The lines pass through a synchronizer first. A change on any of the first five lines latches a pending event. Software clears an event by writing a 1 to its bit. It can also raise an event itself through a force register.

Three output pins are driven from flops. The first is an active-low interrupt, gated by mask bit 15. The second is a status-change flag, asserted when a pending event in bits 0 to 4 has its mask bit set. The third is an audio output. Mask bits 5 and 6 select either the binary audio input or the PWM audio input as its source.

Top module: `fn_status_regs`

## Requirements
- R1: After reset the event and mask registers read 0, `irq_n` is 1, and `stschg` and `aud_out` are 0.
- R2: Offset 0x8 reads present state with bit 0 write protect, bit 1 ready, bit 2 battery detect 2, bit 3 battery detect 1, bit 4 wake, bit 15 interrupt request, and all other bits 0. The value appears two clock edges after an input change. Writes to 0x8 have no effect.
- R3: A change on a status line in bits 0 to 4 sets the matching bit of the event register (offset 0x0) on the third clock edge after the change.
- R4: A change on the interrupt request line updates present-state bit 15 but never sets event bit 15.
- R5: Writing to offset 0x0 clears each event bit written as 1 and leaves bits written as 0 unchanged.
- R6: Writing a 1 to a bit of the force register (offset 0xC) sets that event bit, for bits 0 to 4 and 15. Offset 0xC reads 0.
- R7: One edge after the registers change, `irq_n` is 0 exactly when mask bit 15 is set and either present-state bit 15 or event bit 15 is 1.
- R8: One edge after the registers change, `stschg` is 1 exactly when some event bit in positions 0 to 4 has its mask bit set.
- R9: With mask bit 5 set and bit 6 clear, `aud_out` follows `aud_bin`. With bit 6 set and bit 5 clear, it follows `aud_pwm`. With both bits set or both clear, it is 0. The output lags its inputs by one edge.
- R10: The mask register (offset 0x4) stores only bits 0 to 6 and bit 15. Its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| st_wp | input | 1 | Write protect status |
| st_ready | input | 1 | Ready status |
| st_bvd2 | input | 1 | Battery voltage detect 2 |
| st_bvd1 | input | 1 | Battery voltage detect 1 |
| st_wake | input | 1 | General wake status |
| st_irq | input | 1 | Interrupt request level |
| aud_bin | input | 1 | Binary audio source |
| aud_pwm | input | 1 | PWM audio source |
| irq_n | output | 1 | Active-low interrupt |
| stschg | output | 1 | Status-change flag |
| aud_out | output | 1 | Selected audio |

## Verification
A status change driven between edges appears in present state after the second edge and in the event register after the third. It reaches `stschg` after the fourth. A register write takes effect on the edge that captures it, and the pin outputs follow one edge later. The bench drives and samples on falling edges. It checks present state and event one falling edge apart, which confirms both the arrival cycle and that the event is not early. Each pin check comes exactly one falling edge after the write or input change that affects it.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int REG_W  = 16;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 4;
    localparam int NSTAT  = 6;
    localparam int NEDGE  = 5;

    localparam logic [ADDR_W-1:0] OFF_EVENT = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_MASK  = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_PRES  = 4'h8;
    localparam logic [ADDR_W-1:0] OFF_FORCE = 4'hC;

    localparam int B_IRQ     = 15;
    localparam int B_AUD_BIN = 5;
    localparam int B_AUD_PWM = 6;

    localparam logic [REG_W-1:0] EV_BITS   = 16'h801F;
    localparam logic [REG_W-1:0] MASK_BITS = 16'h807F;

    typedef struct packed {
        logic [REG_W-1:0] ev;
        logic [REG_W-1:0] mask;
        logic [NEDGE-1:0] prev;
    } core_t;

    typedef struct packed {
        logic irq_n;
        logic stschg;
        logic aud;
    } pins_t;
endpackage

// File: rtl/fsr_sync.sv
module fsr_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d;
        for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/fsr_core.sv
module fsr_core
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [NSTAT-1:0]  stat,
    output logic [REG_W-1:0]  ev_q,
    output logic [REG_W-1:0]  mask_q,
    output logic [REG_W-1:0]  pres
);
    core_t q, d;
    logic [REG_W-1:0] set_v, clr_v;
    logic [NEDGE-1:0] chg;

    assign pres = {stat[NSTAT-1], {(REG_W-NEDGE-1){1'b0}}, stat[NEDGE-1:0]};

    always_comb begin
        chg   = stat[NEDGE-1:0] ^ q.prev;
        set_v = {{(REG_W-NEDGE){1'b0}}, chg};
        clr_v = '0;
        if (wr_en && addr == OFF_FORCE) set_v = set_v | (wdata & EV_BITS);
        if (wr_en && addr == OFF_EVENT) clr_v = wdata & EV_BITS;
        d      = q;
        d.ev   = ((q.ev & ~clr_v) | set_v) & EV_BITS;
        d.prev = stat[NEDGE-1:0];
        if (wr_en && addr == OFF_MASK) d.mask = wdata & MASK_BITS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ev_q   = q.ev;
    assign mask_q = q.mask;

    // R6: a forced bit is pending on the next cycle
    a_r6_force_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_FORCE && wdata[B_IRQ]) |=> ev_q[B_IRQ]);
    // R5: a write-one clears the bit (no set source shares that cycle for bit 15)
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_EVENT && wdata[B_IRQ]) |=> !ev_q[B_IRQ]);
    // R4: only the force path raises event bit 15
    a_r4_irq_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == OFF_FORCE && wdata[B_IRQ]) |=> !$rose(ev_q[B_IRQ]));
endmodule

// File: rtl/fsr_pins.sv
module fsr_pins
    import fsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] ev,
    input  logic [REG_W-1:0] mask,
    input  logic             pres_irq,
    input  logic             aud_bin,
    input  logic             aud_pwm,
    output logic             irq_n,
    output logic             stschg,
    output logic             aud_out
);
    pins_t q, d;
    logic  en_bin, en_pwm;

    always_comb begin
        en_bin   = mask[B_AUD_BIN];
        en_pwm   = mask[B_AUD_PWM];
        d.irq_n  = !(mask[B_IRQ] && (pres_irq || ev[B_IRQ]));
        d.stschg = |(ev[NEDGE-1:0] & mask[NEDGE-1:0]);
        unique case ({en_pwm, en_bin})
            2'b01:   d.aud = aud_bin;
            2'b10:   d.aud = aud_pwm;
            default: d.aud = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{irq_n: 1'b1, stschg: 1'b0, aud: 1'b0};
        else        q <= d;
    end

    assign irq_n   = q.irq_n;
    assign stschg  = q.stschg;
    assign aud_out = q.aud;
endmodule

// File: rtl/fn_status_regs.sv
module fn_status_regs
    import fsr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              st_wp,
    input  logic              st_ready,
    input  logic              st_bvd2,
    input  logic              st_bvd1,
    input  logic              st_wake,
    input  logic              st_irq,
    input  logic              aud_bin,
    input  logic              aud_pwm,
    output logic              irq_n,
    output logic              stschg,
    output logic              aud_out
);
    logic [NSTAT-1:0] stat_raw, stat_s;
    logic [REG_W-1:0] ev_q, mask_q, pres;

    assign stat_raw = {st_irq, st_wake, st_bvd1, st_bvd2, st_ready, st_wp};

    fsr_sync #(.W(NSTAT), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(stat_raw), .q(stat_s));

    fsr_core u_core (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata[REG_W-1:0]), .stat(stat_s),
        .ev_q(ev_q), .mask_q(mask_q), .pres(pres));

    fsr_pins u_pins (
        .clk(clk), .rst_n(rst_n), .ev(ev_q), .mask(mask_q),
        .pres_irq(pres[B_IRQ]), .aud_bin(aud_bin), .aud_pwm(aud_pwm),
        .irq_n(irq_n), .stschg(stschg), .aud_out(aud_out));

    always_comb begin
        unique case (bus_addr)
            OFF_EVENT: bus_rdata = {{(BUS_W-REG_W){1'b0}}, ev_q};
            OFF_MASK:  bus_rdata = {{(BUS_W-REG_W){1'b0}}, mask_q};
            OFF_PRES:  bus_rdata = {{(BUS_W-REG_W){1'b0}}, pres};
            default:   bus_rdata = '0;
        endcase
    end

    // R7: with the interrupt mask clear the pin stays high
    a_r7_masked_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_q[B_IRQ] |=> irq_n);
    // R8: no enabled status source, no status change
    a_r8_masked_stschg: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q[NEDGE-1:0] == '0) |=> !stschg);
    // R9: both or neither audio enable gives silence
    a_r9_audio_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q[B_AUD_BIN] == mask_q[B_AUD_PWM]) |=> !aud_out);
endmodule

// File: tb/sim_fn_status_regs.sv
module sim_fn_status_regs;
    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic st_wp = 0, st_ready = 0, st_bvd2 = 0, st_bvd1 = 0, st_wake = 0, st_irq = 0;
    logic aud_bin = 0, aud_pwm = 0;
    logic irq_n, stschg, aud_out;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fn_status_regs u0 (.*);

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] v);
        bus_wr = 1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] v);
        bus_addr = a; #0.5; v = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'h0, v); chk("R1 event", v, 0);
        rd(4'h4, v); chk("R1 mask", v, 0);
        chk("R1 irq_n", irq_n, 1); chk("R1 stschg", stschg, 0); chk("R1 aud", aud_out, 0);
    endtask

    task automatic t_events();
        logic [31:0] v;
        st_ready = 1; st_bvd1 = 1;
        @(negedge clk); @(negedge clk);
        rd(4'h8, v); chk("R2 present after 2 edges", v, 32'h000A);
        rd(4'h0, v); chk("R3 event not before 3rd edge", v, 0);
        @(negedge clk);
        rd(4'h0, v); chk("R3 event set", v, 32'h000A);
        chk("R8 stschg masked", stschg, 0);
        wr(4'h4, 32'h0000_0008);
        @(negedge clk);
        chk("R8 stschg enabled", stschg, 1);
    endtask

    task automatic t_clear_ro();
        logic [31:0] v;
        wr(4'h0, 32'h0);
        rd(4'h0, v); chk("R5 write zero keeps", v, 32'h000A);
        wr(4'h8, 32'h12345678);
        rd(4'h8, v); chk("R2 present read-only", v, 32'h000A);
        wr(4'h0, 32'h0008);
        rd(4'h0, v); chk("R5 clear one bit", v, 32'h0002);
        @(negedge clk);
        chk("R8 stschg drops", stschg, 0);
        wr(4'h0, 32'hFFFF);
        rd(4'h0, v); chk("R5 clear all", v, 0);
        wr(4'hF - 4'h3, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        st_irq = 1;
        repeat (4) @(negedge clk);
        rd(4'h8, v); chk("R4 present irq", v, 32'h800A);
        rd(4'h0, v); chk("R4 no irq event", v, 0);
        chk("R7 irq masked by default", irq_n, 1);
        wr(4'h4, 32'h8000);
        @(negedge clk);
        chk("R7 irq from present", irq_n, 0);
        wr(4'h4, 32'h0);
        @(negedge clk);
        chk("R7 masked present", irq_n, 1);
        st_irq = 0;
        repeat (4) @(negedge clk);
        rd(4'h0, v); chk("R4 no event on fall", v, 0);
        wr(4'hC, 32'h8000);
        rd(4'h0, v); chk("R6 force sets 15", v, 32'h8000);
        rd(4'hC, v); chk("R6 force reads 0", v, 0);
        @(negedge clk);
        chk("R7 masked forced", irq_n, 1);
        wr(4'h4, 32'h8000);
        @(negedge clk);
        chk("R7 irq from event", irq_n, 0);
        wr(4'h0, 32'h8000);
        @(negedge clk);
        chk("R7 irq released", irq_n, 1);
        wr(4'hC, 32'h0011);
        rd(4'h0, v); chk("R6 force low bits", v, 32'h0011);
        wr(4'h0, 32'hFFFF);
    endtask

    task automatic t_mask_audio();
        logic [31:0] v;
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, v); chk("R10 mask width", v, 32'h807F);
        aud_bin = 1; aud_pwm = 0;
        @(negedge clk);
        chk("R9 both enabled", aud_out, 0);
        wr(4'h4, 32'h0020);
        @(negedge clk);
        chk("R9 bin high", aud_out, 1);
        aud_bin = 0;
        @(negedge clk);
        chk("R9 bin low", aud_out, 0);
        aud_pwm = 1;
        @(negedge clk);
        chk("R9 bin ignores pwm", aud_out, 0);
        wr(4'h4, 32'h0040);
        @(negedge clk);
        chk("R9 pwm high", aud_out, 1);
        wr(4'h4, 32'h0);
        @(negedge clk);
        chk("R9 none enabled", aud_out, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_events();
        t_clear_ro();
        t_irq();
        t_mask_audio();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule